// File: doc/BRIEF.md
# Filter Accelerator Control and Register Block

This block is the software-facing front of a multiply-accumulate filter engine. It holds eight word-aligned registers behind a simple register bus: three buffer configuration words, a function parameter word with the START bit, a control word, a status word, and two data ports. It drives the configuration, the enables and the START state onto the datapath and the pointer logic, and it takes their status back as inputs. The datapath and the pointer logic are separate blocks.

A small sequencer sets the START state. Writing the parameter word with START set either begins a buffer preload or begins a filter computation. Any other function code leaves START at 0. A preload ends when the pointer logic raises `load_done`. A computation runs until software writes START back to 0. While a function runs, the parameters, the function code, the X2 size and the DMA enables cannot be changed. The X2 base stays writable.

The soft reset bit in the control word clears the parameters, START and the sticky error flags, and pulses `ptr_clear` for one cycle. It leaves the other configuration alone. One level-sensitive `irq` is the OR of five enabled sources.

Sequencer states and transitions:
- IDLE goes to LOAD on a START write with code 1, 2 or 3.
- IDLE goes to COMPUTE on a START write with code 8 or 9.
- LOAD goes to IDLE when `load_done` is seen or when START is written to 0.
- COMPUTE goes to IDLE when START is written to 0.
- Any state goes to SRESET on a soft reset write.
- SRESET goes to IDLE after one cycle.

Top module: `accel_ctrl_regs`

## Requirements
- R1: The register offsets are fixed.
  - 0x00 X1 config: base [7:0], size [15:8], watermark [25:24].
  - 0x04 X2 config: base [7:0], size [15:8].
  - 0x08 Y config: base [7:0], size [15:8], watermark [25:24].
  - 0x0C parameters: P [7:0], Q [15:8], R [23:16], function code [30:24], START [31].
  - 0x10 control: read irq enable [0], write irq enable [1], overflow irq enable [2], underflow irq enable [3], saturation irq enable [4], DMA read enable [8], DMA write enable [9], clip [15], soft reset [16].
  - 0x14 status.
  - 0x18 write data.
  - 0x1C read data.
  - `bus_rdata` is a combinational view of the addressed register. Bits that are not listed read 0.
- R2: Function codes 1, 2 and 3 are preloads. A START write with one of these codes while idle sets START. START returns to 0 one cycle after a cycle in which `load_done` is 1.
- R3: Function codes 8 and 9 are computations. A START write with one of these codes while idle sets START. START then stays at 1 whatever `load_done` does.
- R4: While START is 1, writes to P, Q, R, the function code, the X2 size and the two DMA enables leave those fields unchanged. Writes to the X2 base and to the other control bits still take effect.
- R5: A parameter write with bit 31 at 0 while START is 1 clears START and stops the function. The locked fields keep their values.
- R6: A START write while idle with any other function code (0, the reserved codes 4 to 7, or other values) leaves START at 0. The non-START fields are still stored.
- R7: `irq` is a level signal. It is 1 exactly when at least one of these sources is active:
  - the read enable is set and `y_empty` is 0;
  - the write enable is set and `x1_full` is 0;
  - a sticky error flag is set and its own enable is set.
- R8: The status word returns `y_empty` in [0], `x1_full` in [1], overflow in [8], underflow in [9] and saturation in [10].
  - Overflow latches when the write-data port is written while `x1_nospace` is 1.
  - Underflow latches when the read-data port is read while `y_nodata` is 1.
  - Saturation latches on `sat_evt`.
  - The flags are sticky, and writes to the status word are ignored.
- R9: A control write with bit 16 at 1 has the following effects:
  - From the next cycle, the parameter word reads 0 and START is 0.
  - The three error flags are clear.
  - `ptr_clear` is 1 and control bit 16 reads 1, for exactly one cycle, then both return to 0.
  - The buffer configuration words keep their values.
  - Parameter writes in that one cycle are ignored.
- R10: A write to 0x18 raises `wr_push` in the same cycle, with `wr_sample` equal to the low 16 data bits. A read of 0x1C raises `rd_pop` in the same cycle and returns `ybuf_rdata` in the low 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| y_empty | input | 1 | Y buffer below its empty watermark |
| x1_full | input | 1 | X1 buffer below its free-space watermark |
| x1_nospace | input | 1 | X1 buffer has no free entry |
| y_nodata | input | 1 | Y buffer has no unread entry |
| sat_evt | input | 1 | Accumulator saturation event |
| load_done | input | 1 | Preload finished |
| ybuf_rdata | input | SAMPLE_W | Sample at the Y read pointer |
| wr_push | output | 1 | Push a sample into X1 |
| wr_sample | output | SAMPLE_W | Sample to push |
| rd_pop | output | 1 | Advance the Y read pointer |
| x1_base | output | BASE_W | X1 base address |
| x1_size | output | SIZE_W | X1 size |
| x1_wm | output | WM_W | X1 watermark code |
| x2_base | output | BASE_W | X2 base address |
| x2_size | output | SIZE_W | X2 size |
| y_base | output | BASE_W | Y base address |
| y_size | output | SIZE_W | Y size |
| y_wm | output | WM_W | Y watermark code |
| prm_p | output | PRM_W | Parameter P |
| prm_q | output | PRM_W | Parameter Q |
| prm_r | output | PRM_W | Parameter R |
| func_code | output | FUNC_W | Function code |
| start | output | 1 | Function running |
| clip_en | output | 1 | Clipping enable |
| dma_rd_en | output | 1 | DMA read enable |
| dma_wr_en | output | 1 | DMA write enable |
| ptr_clear | output | 1 | One-cycle pointer clear from soft reset |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded properties check a set of behaviours on every clock cycle:
- the field locks while START is set;
- the clearing of START after a preload completes, and its persistence during a computation;
- the rejection of reserved codes;
- the stickiness of the error flags;
- the one-cycle soft reset pulse and what it clears.

Only the bench's scenarios can show the full picture. These cover the exact readback layout of each register and the X2 base staying writable while running. They also cover the OR of the interrupt sources under each enable, the pass-through timing of the data ports, and the configuration words that survive a soft reset. The bench's reference model compares the readback, START, `irq` and the strobes on every cycle.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_COMPUTE = 2'd2,
        ST_SRESET  = 2'd3
    } seq_state_t;

    // register byte offsets
    localparam int OFS_X1CFG = 'h00;
    localparam int OFS_X2CFG = 'h04;
    localparam int OFS_YCFG  = 'h08;
    localparam int OFS_PARAM = 'h0C;
    localparam int OFS_CTRL  = 'h10;
    localparam int OFS_STAT  = 'h14;
    localparam int OFS_WDATA = 'h18;
    localparam int OFS_RDATA = 'h1C;

    // field positions
    localparam int WM_LSB      = 24;
    localparam int FUNC_LSB    = 24;
    localparam int START_BIT   = 31;
    localparam int NUM_IRQ     = 5;
    localparam int DMA_RD_BIT  = 8;
    localparam int DMA_WR_BIT  = 9;
    localparam int CLIP_BIT    = 15;
    localparam int SRST_BIT    = 16;
    localparam int OVFL_BIT    = 8;
    localparam int UNFL_BIT    = 9;
    localparam int SAT_BIT     = 10;

    // function codes
    localparam int FN_LOAD_X1 = 1;
    localparam int FN_LOAD_X2 = 2;
    localparam int FN_LOAD_Y  = 3;
    localparam int FN_FIR     = 8;
    localparam int FN_IIR     = 9;

endpackage

// File: rtl/accel_cfg_regs.sv
module accel_cfg_regs
    import accel_ctrl_pkg::*;
#(
    parameter int BASE_W = 8,
    parameter int SIZE_W = 8,
    parameter int WM_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_x1,
    input  logic                wr_x2,
    input  logic                wr_y,
    input  logic                wr_cr,
    input  logic                running,
    input  logic [31:0]         wdata,
    output logic [BASE_W-1:0]   x1_base,
    output logic [SIZE_W-1:0]   x1_size,
    output logic [WM_W-1:0]     x1_wm,
    output logic [BASE_W-1:0]   x2_base,
    output logic [SIZE_W-1:0]   x2_size,
    output logic [BASE_W-1:0]   y_base,
    output logic [SIZE_W-1:0]   y_size,
    output logic [WM_W-1:0]     y_wm,
    output logic [NUM_IRQ-1:0]  irq_en,
    output logic                dma_rd_en,
    output logic                dma_wr_en,
    output logic                clip_en,
    output logic                soft_rst_req
);

    localparam int SZ_LSB = BASE_W;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[23:17], wdata[31:26]};

    assign soft_rst_req = wr_cr & wdata[SRST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1_base <= '0; x1_size <= '0; x1_wm <= '0;
            y_base  <= '0; y_size  <= '0; y_wm  <= '0;
        end else begin
            if (wr_x1) begin
                x1_base <= wdata[0 +: BASE_W];
                x1_size <= wdata[SZ_LSB +: SIZE_W];
                x1_wm   <= wdata[WM_LSB +: WM_W];
            end
            if (wr_y) begin
                y_base <= wdata[0 +: BASE_W];
                y_size <= wdata[SZ_LSB +: SIZE_W];
                y_wm   <= wdata[WM_LSB +: WM_W];
            end
        end
    end

    // X2 base stays writable while running; the size does not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x2_base <= '0;
            x2_size <= '0;
        end else if (wr_x2) begin
            x2_base <= wdata[0 +: BASE_W];
            if (!running) x2_size <= wdata[SZ_LSB +: SIZE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en    <= '0;
            clip_en   <= 1'b0;
            dma_rd_en <= 1'b0;
            dma_wr_en <= 1'b0;
        end else if (wr_cr) begin
            irq_en  <= wdata[0 +: NUM_IRQ];
            clip_en <= wdata[CLIP_BIT];
            if (!running) begin
                dma_rd_en <= wdata[DMA_RD_BIT];
                dma_wr_en <= wdata[DMA_WR_BIT];
            end
        end
    end

    p_x2size_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_x2) |=> $stable(x2_size));

    p_dma_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_cr) |=> ($stable(dma_rd_en) && $stable(dma_wr_en)));

    p_x2base_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_x2 |=> (x2_base == $past(wdata[0 +: BASE_W])));

endmodule

// File: rtl/accel_seq_fsm.sv
module accel_seq_fsm
    import accel_ctrl_pkg::*;
#(
    parameter int PRM_W  = 8,
    parameter int FUNC_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_param,
    input  logic [31:0]       wdata,
    input  logic              soft_rst_req,
    input  logic              load_done,
    output logic [PRM_W-1:0]  prm_p,
    output logic [PRM_W-1:0]  prm_q,
    output logic [PRM_W-1:0]  prm_r,
    output logic [FUNC_W-1:0] func_code,
    output logic              start,
    output logic              ptr_clear
);

    seq_state_t state, state_nxt;

    logic [FUNC_W-1:0] wfunc;
    logic              w_start, is_load, is_calc;

    assign wfunc   = wdata[FUNC_LSB +: FUNC_W];
    assign w_start = wdata[START_BIT];
    assign is_load = (wfunc == FUNC_W'(FN_LOAD_X1)) || (wfunc == FUNC_W'(FN_LOAD_X2))
                  || (wfunc == FUNC_W'(FN_LOAD_Y));
    assign is_calc = (wfunc == FUNC_W'(FN_FIR)) || (wfunc == FUNC_W'(FN_IIR));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (soft_rst_req)                      state_nxt = ST_SRESET;
                else if (wr_param && w_start && is_load) state_nxt = ST_LOAD;
                else if (wr_param && w_start && is_calc) state_nxt = ST_COMPUTE;
            end
            ST_LOAD: begin
                if (soft_rst_req)                state_nxt = ST_SRESET;
                else if (wr_param && !w_start)   state_nxt = ST_IDLE;
                else if (load_done)              state_nxt = ST_IDLE;
            end
            ST_COMPUTE: begin
                if (soft_rst_req)                state_nxt = ST_SRESET;
                else if (wr_param && !w_start)   state_nxt = ST_IDLE;
            end
            ST_SRESET: begin
                state_nxt = soft_rst_req ? ST_SRESET : ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start     = 1'b0;
        ptr_clear = 1'b0;
        unique case (state)
            ST_LOAD, ST_COMPUTE: start     = 1'b1;
            ST_SRESET:           ptr_clear = 1'b1;
            default: ;
        endcase
    end

    // parameter fields, written only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prm_p <= '0; prm_q <= '0; prm_r <= '0; func_code <= '0;
        end else if (soft_rst_req) begin
            prm_p <= '0; prm_q <= '0; prm_r <= '0; func_code <= '0;
        end else if (wr_param && state == ST_IDLE) begin
            prm_p     <= wdata[0 +: PRM_W];
            prm_q     <= wdata[PRM_W +: PRM_W];
            prm_r     <= wdata[2*PRM_W +: PRM_W];
            func_code <= wfunc;
        end
    end

    p_reserved_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !ptr_clear && wr_param && w_start && !soft_rst_req
         && !is_load && !is_calc) |=> !start);

    p_load_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && func_code >= FUNC_W'(FN_LOAD_X1) && func_code <= FUNC_W'(FN_LOAD_Y)
         && load_done) |=> !start);

    p_calc_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (func_code == FUNC_W'(FN_FIR) || func_code == FUNC_W'(FN_IIR))
         && !wr_param && !soft_rst_req) |=> start);

    p_fields_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wr_param && !soft_rst_req) |=>
            ($stable(prm_p) && $stable(prm_q) && $stable(prm_r) && $stable(func_code)));

    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wr_param && !w_start) |=> !start);

    p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |=> (ptr_clear && !start && func_code == '0 && prm_p == '0));

    p_clear_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_clear && !soft_rst_req) |=> !ptr_clear);

endmodule

// File: rtl/accel_irq_status.sv
module accel_irq_status
    import accel_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               ovfl_evt,
    input  logic               unfl_evt,
    input  logic               sat_evt,
    input  logic               y_empty,
    input  logic               x1_full,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               ovfl,
    output logic               unfl,
    output logic               sat,
    output logic               irq
);

    logic [NUM_IRQ-1:0] src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovfl <= 1'b0; unfl <= 1'b0; sat <= 1'b0;
        end else if (soft_clr) begin
            ovfl <= 1'b0; unfl <= 1'b0; sat <= 1'b0;
        end else begin
            ovfl <= ovfl | ovfl_evt;
            unfl <= unfl | unfl_evt;
            sat  <= sat  | sat_evt;
        end
    end

    assign src = {sat, unfl, ovfl, ~x1_full, ~y_empty};
    assign irq = |(src & irq_en);

    p_ovfl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovfl && !soft_clr) |=> ovfl);

    p_unfl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unfl && !soft_clr) |=> unfl);

    p_flags_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!ovfl && !unfl && !sat));

    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
    import accel_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int SAMPLE_W = 16,
    parameter int BASE_W   = 8,
    parameter int SIZE_W   = 8,
    parameter int WM_W     = 2,
    parameter int PRM_W    = 8,
    parameter int FUNC_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                y_empty,
    input  logic                x1_full,
    input  logic                x1_nospace,
    input  logic                y_nodata,
    input  logic                sat_evt,
    input  logic                load_done,
    input  logic [SAMPLE_W-1:0] ybuf_rdata,
    output logic                wr_push,
    output logic [SAMPLE_W-1:0] wr_sample,
    output logic                rd_pop,
    output logic [BASE_W-1:0]   x1_base,
    output logic [SIZE_W-1:0]   x1_size,
    output logic [WM_W-1:0]     x1_wm,
    output logic [BASE_W-1:0]   x2_base,
    output logic [SIZE_W-1:0]   x2_size,
    output logic [BASE_W-1:0]   y_base,
    output logic [SIZE_W-1:0]   y_size,
    output logic [WM_W-1:0]     y_wm,
    output logic [PRM_W-1:0]    prm_p,
    output logic [PRM_W-1:0]    prm_q,
    output logic [PRM_W-1:0]    prm_r,
    output logic [FUNC_W-1:0]   func_code,
    output logic                start,
    output logic                clip_en,
    output logic                dma_rd_en,
    output logic                dma_wr_en,
    output logic                ptr_clear,
    output logic                irq
);

    logic               wr_x1, wr_x2, wr_y, wr_param, wr_cr;
    logic               soft_rst_req;
    logic [NUM_IRQ-1:0] irq_en;
    logic               ovfl, unfl, sat;

    assign wr_x1    = bus_wr && (bus_addr == ADDR_W'(OFS_X1CFG));
    assign wr_x2    = bus_wr && (bus_addr == ADDR_W'(OFS_X2CFG));
    assign wr_y     = bus_wr && (bus_addr == ADDR_W'(OFS_YCFG));
    assign wr_param = bus_wr && (bus_addr == ADDR_W'(OFS_PARAM));
    assign wr_cr    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_push  = bus_wr && (bus_addr == ADDR_W'(OFS_WDATA));
    assign rd_pop   = bus_rd && (bus_addr == ADDR_W'(OFS_RDATA));
    assign wr_sample = bus_wdata[SAMPLE_W-1:0];

    accel_cfg_regs #(.BASE_W(BASE_W), .SIZE_W(SIZE_W), .WM_W(WM_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_x1(wr_x1), .wr_x2(wr_x2), .wr_y(wr_y), .wr_cr(wr_cr),
        .running(start), .wdata(bus_wdata),
        .x1_base(x1_base), .x1_size(x1_size), .x1_wm(x1_wm),
        .x2_base(x2_base), .x2_size(x2_size),
        .y_base(y_base), .y_size(y_size), .y_wm(y_wm),
        .irq_en(irq_en), .dma_rd_en(dma_rd_en), .dma_wr_en(dma_wr_en),
        .clip_en(clip_en), .soft_rst_req(soft_rst_req)
    );

    accel_seq_fsm #(.PRM_W(PRM_W), .FUNC_W(FUNC_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_param(wr_param), .wdata(bus_wdata),
        .soft_rst_req(soft_rst_req), .load_done(load_done),
        .prm_p(prm_p), .prm_q(prm_q), .prm_r(prm_r), .func_code(func_code),
        .start(start), .ptr_clear(ptr_clear)
    );

    accel_irq_status u_irq (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst_req),
        .ovfl_evt(wr_push && x1_nospace),
        .unfl_evt(rd_pop && y_nodata),
        .sat_evt(sat_evt),
        .y_empty(y_empty), .x1_full(x1_full), .irq_en(irq_en),
        .ovfl(ovfl), .unfl(unfl), .sat(sat), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_X1CFG): begin
                bus_rdata[0 +: BASE_W]      = x1_base;
                bus_rdata[BASE_W +: SIZE_W] = x1_size;
                bus_rdata[WM_LSB +: WM_W]   = x1_wm;
            end
            ADDR_W'(OFS_X2CFG): begin
                bus_rdata[0 +: BASE_W]      = x2_base;
                bus_rdata[BASE_W +: SIZE_W] = x2_size;
            end
            ADDR_W'(OFS_YCFG): begin
                bus_rdata[0 +: BASE_W]      = y_base;
                bus_rdata[BASE_W +: SIZE_W] = y_size;
                bus_rdata[WM_LSB +: WM_W]   = y_wm;
            end
            ADDR_W'(OFS_PARAM): begin
                bus_rdata[0 +: PRM_W]        = prm_p;
                bus_rdata[PRM_W +: PRM_W]    = prm_q;
                bus_rdata[2*PRM_W +: PRM_W]  = prm_r;
                bus_rdata[FUNC_LSB +: FUNC_W] = func_code;
                bus_rdata[START_BIT]         = start;
            end
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[0 +: NUM_IRQ]  = irq_en;
                bus_rdata[DMA_RD_BIT]    = dma_rd_en;
                bus_rdata[DMA_WR_BIT]    = dma_wr_en;
                bus_rdata[CLIP_BIT]      = clip_en;
                bus_rdata[SRST_BIT]      = ptr_clear;
            end
            ADDR_W'(OFS_STAT): begin
                bus_rdata[0]        = y_empty;
                bus_rdata[1]        = x1_full;
                bus_rdata[OVFL_BIT] = ovfl;
                bus_rdata[UNFL_BIT] = unfl;
                bus_rdata[SAT_BIT]  = sat;
            end
            ADDR_W'(OFS_RDATA): bus_rdata[0 +: SAMPLE_W] = ybuf_rdata;
            default: ;
        endcase
    end

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ovfl && !unfl && !sat) |-> (!y_empty || !x1_full));

endmodule

// File: tb/test_accel_ctrl_regs.sv
`timescale 1ns/1ps
module test_accel_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        y_empty = 1'b1, x1_full = 1'b1, x1_nospace = 1'b0, y_nodata = 1'b0;
    logic        sat_evt = 1'b0, load_done = 1'b0;
    logic [15:0] ybuf_rdata = '0;
    logic        wr_push, rd_pop, start, clip_en, dma_rd_en, dma_wr_en, ptr_clear, irq;
    logic [15:0] wr_sample;
    logic [7:0]  x1_base, x1_size, x2_base, x2_size, y_base, y_size, prm_p, prm_q, prm_r;
    logic [1:0]  x1_wm, y_wm;
    logic [6:0]  func_code;

    always #4 clk = ~clk;   // 125 MHz

    accel_ctrl_regs i_accel_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .y_empty(y_empty), .x1_full(x1_full),
        .x1_nospace(x1_nospace), .y_nodata(y_nodata), .sat_evt(sat_evt), .load_done(load_done),
        .ybuf_rdata(ybuf_rdata), .wr_push(wr_push), .wr_sample(wr_sample), .rd_pop(rd_pop),
        .x1_base(x1_base), .x1_size(x1_size), .x1_wm(x1_wm), .x2_base(x2_base),
        .x2_size(x2_size), .y_base(y_base), .y_size(y_size), .y_wm(y_wm),
        .prm_p(prm_p), .prm_q(prm_q), .prm_r(prm_r), .func_code(func_code), .start(start),
        .clip_en(clip_en), .dma_rd_en(dma_rd_en), .dma_wr_en(dma_wr_en),
        .ptr_clear(ptr_clear), .irq(irq)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_x1 = 0, m_x2 = 0, m_y = 0, m_prm = 0, m_cr = 0;
    bit m_ovfl = 0, m_unfl = 0, m_sat = 0;
    int st = 0; // 0 idle, 1 preload, 2 compute, 3 soft reset

    always @(posedge clk) begin
        if (!rst_n) begin
            m_x1 = 0; m_x2 = 0; m_y = 0; m_prm = 0; m_cr = 0;
            m_ovfl = 0; m_unfl = 0; m_sat = 0; st = 0;
        end else begin
            automatic bit run = (st == 1 || st == 2);
            automatic int nst = (st == 3) ? 0 : st;
            automatic bit srst = 0;
            if (bus_wr) begin
                case (bus_addr)
                    6'h00: m_x1 = bus_wdata & 32'h0300FFFF;
                    6'h04: if (run) m_x2[7:0] = bus_wdata[7:0];
                           else m_x2 = bus_wdata & 32'h0000FFFF;
                    6'h08: m_y = bus_wdata & 32'h0300FFFF;
                    6'h10: begin
                        if (run) m_cr = (m_cr & 32'h300) | (bus_wdata & 32'h801F);
                        else     m_cr = bus_wdata & 32'h831F;
                        if (bus_wdata[16]) begin nst = 3; m_prm = 0; srst = 1; end
                    end
                    6'h0C: if (st != 3) begin
                        if (!run) begin
                            automatic int code = int'(bus_wdata[30:24]);
                            m_prm = bus_wdata & 32'h7FFFFFFF;
                            if (bus_wdata[31]) begin
                                if (code >= 1 && code <= 3) nst = 1;
                                else if (code == 8 || code == 9) nst = 2;
                            end
                        end else if (!bus_wdata[31]) nst = 0;
                    end
                    default: ;
                endcase
            end
            if (st == 1 && load_done && nst == 1) nst = 0;
            if (srst) begin
                m_ovfl = 0; m_unfl = 0; m_sat = 0;
            end else begin
                if (bus_wr && bus_addr == 6'h18 && x1_nospace) m_ovfl = 1;
                if (bus_rd && bus_addr == 6'h1C && y_nodata) m_unfl = 1;
                if (sat_evt) m_sat = 1;
            end
            st = nst;
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (bus_addr)
            6'h00: return m_x1;
            6'h04: return m_x2;
            6'h08: return m_y;
            6'h0C: return m_prm | {(st == 1 || st == 2), 31'b0};
            6'h10: return m_cr | ((st == 3) ? 32'h10000 : 32'h0);
            6'h14: return {21'b0, m_sat, m_unfl, m_ovfl, 6'b0, x1_full, y_empty};
            6'h1C: return {16'b0, ybuf_rdata};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_cr[0] && !y_empty) || (m_cr[1] && !x1_full) || (m_cr[2] && m_ovfl)
            || (m_cr[3] && m_unfl) || (m_cr[4] && m_sat);
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            chk("R1 cycle readback", bus_rdata, exp_rdata());
            chk("R3 cycle start", {31'b0, start}, {31'b0, (st == 1 || st == 2)});
            chk("R7 cycle irq", {31'b0, irq}, {31'b0, exp_irq()});
            chk("R4 cycle cfg outputs", {x2_size, x2_base, prm_p, 1'b0, func_code},
                {m_x2[15:8], m_x2[7:0], m_prm[7:0], 1'b0, m_prm[30:24]});
            chk("R10 cycle strobes",
                {26'b0, wr_push, rd_pop, ptr_clear, clip_en, dma_rd_en, dma_wr_en},
                {26'b0, bus_wr && bus_addr == 6'h18, bus_rd && bus_addr == 6'h1C,
                 st == 3, m_cr[15], m_cr[8], m_cr[9]});
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // reset state
        peek(6'h0C, 32'h0, "R1 reset param");
        peek(6'h10, 32'h0, "R1 reset ctrl");
        peek(6'h14, 32'h3, "R8 reset status");
        chk("R3 reset start", {31'b0, start}, 32'h0);

        // configuration readback
        wr(6'h00, 32'hFF03_1234); peek(6'h00, 32'h0300_1234, "R1 X1 config");
        chk("R1 X1 watermark out", {30'b0, x1_wm}, 32'h3);
        wr(6'h04, 32'hABCD_5678); peek(6'h04, 32'h0000_5678, "R1 X2 config");
        wr(6'h08, 32'h0201_2233); peek(6'h08, 32'h0200_2233, "R1 Y config");
        wr(6'h10, 32'h0000_8300); peek(6'h10, 32'h0000_8300, "R1 ctrl");

        // computation start and locks
        wr(6'h0C, 32'h8811_2233); peek(6'h0C, 32'h8811_2233, "R3 FIR start");
        wr(6'h0C, 32'h8855_6677); peek(6'h0C, 32'h8811_2233, "R4 params locked");
        wr(6'h04, 32'h0000_99AA); peek(6'h04, 32'h0000_56AA, "R4 X2 base open size locked");
        wr(6'h10, 32'h0000_0000); peek(6'h10, 32'h0000_0300, "R4 DMA locked clip open");
        @(negedge clk); load_done = 1'b1; @(negedge clk); load_done = 1'b0;
        idle(1);
        chk("R3 load_done ignored in compute", {31'b0, start}, 32'h1);

        // stop
        wr(6'h0C, 32'h0000_0000); peek(6'h0C, 32'h0811_2233, "R5 stop keeps fields");

        // preload
        wr(6'h0C, 32'h8200_0005); idle(3);
        peek(6'h0C, 32'h8200_0005, "R2 preload running");
        @(negedge clk); load_done = 1'b1; @(negedge clk); load_done = 1'b0;
        peek(6'h0C, 32'h0200_0005, "R2 preload self-clears");

        // reserved codes
        wr(6'h0C, 32'h8500_0001); peek(6'h0C, 32'h0500_0001, "R6 reserved code 5");
        wr(6'h0C, 32'h8000_0000); peek(6'h0C, 32'h0000_0000, "R6 code 0");
        wr(6'h0C, 32'hFF00_0000); peek(6'h0C, 32'h7F00_0000, "R6 code 127");

        // interrupts
        wr(6'h10, 32'h0000_0001);
        #2 chk("R7 read irq held by empty", {31'b0, irq}, 32'h0);
        @(negedge clk); y_empty = 1'b0; #2 chk("R7 read irq", {31'b0, irq}, 32'h1);
        @(negedge clk); y_empty = 1'b1;
        wr(6'h10, 32'h0000_0002);
        @(negedge clk); x1_full = 1'b0; #2 chk("R7 write irq", {31'b0, irq}, 32'h1);
        @(negedge clk); x1_full = 1'b1;

        // overflow and write port
        wr(6'h10, 32'h0000_0004);
        @(negedge clk); x1_nospace = 1'b1; bus_wr = 1'b1; bus_addr = 6'h18; bus_wdata = 32'h5555_1234;
        #2 chk("R10 push strobe", {15'b0, wr_push, wr_sample}, 32'h0001_1234);
        @(negedge clk); bus_wr = 1'b0; x1_nospace = 1'b0;
        peek(6'h14, 32'h0000_0103, "R8 overflow flag");
        chk("R7 overflow irq", {31'b0, irq}, 32'h1);

        // underflow and read port
        @(negedge clk); y_nodata = 1'b1; bus_rd = 1'b1; bus_addr = 6'h1C; ybuf_rdata = 16'hBEEF;
        #2 chk("R10 pop strobe and data", {15'b0, rd_pop, bus_rdata[15:0]}, 32'h0001_BEEF);
        @(negedge clk); bus_rd = 1'b0; y_nodata = 1'b0;
        peek(6'h14, 32'h0000_0303, "R8 underflow flag");

        // saturation, stickiness, status write ignored
        @(negedge clk); sat_evt = 1'b1; @(negedge clk); sat_evt = 1'b0;
        peek(6'h14, 32'h0000_0703, "R8 saturation flag");
        wr(6'h14, 32'h0000_0000); peek(6'h14, 32'h0000_0703, "R8 status write ignored");
        wr(6'h10, 32'h0000_0000);
        #2 chk("R7 flags gated off", {31'b0, irq}, 32'h0);
        wr(6'h10, 32'h0000_0010);
        #2 chk("R7 saturation irq", {31'b0, irq}, 32'h1);

        // soft reset
        wr(6'h0C, 32'h8900_0011);
        chk("R3 IIR start", {31'b0, start}, 32'h1);
        wr(6'h10, 32'h0001_0010);
        #2 chk("R9 pointer clear pulse", {31'b0, ptr_clear}, 32'h1);
        peek(6'h10, 32'h0001_0010, "R9 reset bit visible");
        peek(6'h0C, 32'h0000_0000, "R9 params cleared");
        peek(6'h14, 32'h0000_0003, "R9 flags cleared");
        @(negedge clk);
        #2 chk("R9 pulse ends", {31'b0, ptr_clear}, 32'h0);
        peek(6'h10, 32'h0000_0010, "R9 reset bit self-clears");
        peek(6'h00, 32'h0300_1234, "R9 X1 config kept");
        peek(6'h04, 32'h0000_56AA, "R9 X2 config kept");
        idle(2);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule